// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block places a group of I/O banks into a low-power state while an asynchronous low-power request is held high, and brings the device back out under a fixed resume delay. Each bank has its own two-bit action code. The code selects whether that bank's pad outputs go to high impedance, whether its pad inputs are disabled, both, or neither. The block drives one output-enable bit and one input-enable bit per bank toward the pad ring. The pad buffers themselves are outside the block.

When the request falls, a countdown of 10 µs runs. The count is worked out from the clock frequency parameter. A ready flag rises only when the countdown has finished and the PLL reports lock. The PLL can optionally be powered down for the duration of low-power mode. The block never resets any state outside itself; user logic keeps its state across the mode.

Top module: `lps_sequencer`

## Requirements
- R1: After reset every output-enable and input-enable bit is 1, `pll_run_o` is 1 and `ready_o` is 0.
- R2: The request `lp_req_i` passes through a two-flop synchroniser. The registered enables react on the third rising clock edge after the request changes.
- R3: While low-power mode is active, each bank applies its two-bit code from `bank_cfg_i[2b+1:2b]`. Bit 0 set drives that bank's `oe_o` bit to 0, and bit 1 set drives its `ie_o` bit to 0. Code 00 keeps both enables at 1.
- R4: Outside low-power mode every enable bit is 1, whatever the bank codes are.
- R5: `ready_o` is 0 while low-power mode is active. After `lp_req_i` falls, `ready_o` rises exactly RESUME_CYCLES+3 rising edges later, where RESUME_CYCLES = (CLK_FREQ_HZ/1e6)*10, provided `pll_lock_i` is 1.
- R6: If the request is reasserted during the countdown, the countdown restarts in full from the next falling edge of the request.
- R7: `pll_run_o` is 0 while low-power mode is active and `pll_sleep_i` is 1. It is 1 in every other case. A value of 0 requests PLL power-down.
- R8: `ready_o` is 1 only while the PLL reports lock. A lock drop clears `ready_o` on the next rising edge, and a lock return sets it again on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lp_req_i | input | 1 | Asynchronous low-power request, active high |
| bank_cfg_i | input | 2*NUM_BANKS | Per-bank action codes, two bits per bank |
| pll_sleep_i | input | 1 | Power the PLL down during low-power mode |
| pll_lock_i | input | 1 | PLL lock indication |
| oe_o | output | NUM_BANKS | Per-bank output enable (0 = tristate) |
| ie_o | output | NUM_BANKS | Per-bank input enable (0 = disabled) |
| pll_run_o | output | 1 | PLL run control (0 = power down) |
| ready_o | output | 1 | Normal operation resumed |

## Verification
The bench sweeps all 256 combinations of code for four banks. Each combination is tried once with the request held high and once with it low. The first set of runs separates the two enable bits of every bank and catches a swapped bit or a crossed bank. The second set shows that the codes have no effect outside the mode. The PLL sleep bit is toggled across the sweep, which separates a PLL power-down tied to the mode from one tied to the codes. The resume delay is measured edge by edge in three cases: a clean exit, an exit interrupted by a reassertion, and an exit with lock withheld. Together these show an off-by-one count, a timer that does not restart, and a ready flag that ignores lock.

// File: rtl/lps_pkg.sv
// Package: shared types for the low-power sequencer.
// Assumes: a bank action is two bits; bit 0 gates outputs, bit 1 gates inputs.
package lps_pkg;
    typedef enum logic [1:0] {
        BANK_KEEP    = 2'b00,
        BANK_OUT_OFF = 2'b01,
        BANK_IN_OFF  = 2'b10,
        BANK_ALL_OFF = 2'b11
    } bank_act_e;
endpackage

// File: rtl/lps_sync.sv
// Module: two-flop synchroniser for a single asynchronous level.
// Assumes: the input is a slow level, so one-cycle uncertainty is acceptable.
module lps_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic meta_q;

    // Purpose: shift the async level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_o <= 1'b0;
        end else begin
            meta_q <= async_i;
            sync_o <= meta_q;
        end
    end
endmodule

// File: rtl/lps_resume_timer.sv
// Module: resume countdown; reloads while low-power is active, then counts to zero.
// Assumes: CYCLES >= 1; done_o is high at reset (no resume pending).
module lps_resume_timer #(
    parameter int unsigned CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lp_i,
    output logic done_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    // Purpose: hold the full count during low-power, count down after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (lp_i) begin
            cnt_q <= CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign done_o = (cnt_q == '0);

    // R5: the counter never exceeds the programmed delay
    a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(CYCLES));

    // R5: outside low-power the count moves down by exactly one per cycle
    a_r5_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!lp_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

    // R6: a request seen in low-power leaves the full count loaded
    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        lp_i |=> (cnt_q == CW'(CYCLES)));
endmodule

// File: rtl/lps_bank_gate.sv
// Module: enable gating for one I/O bank during low-power mode.
// Assumes: the action code may change at any time and is used live.
module lps_bank_gate
    import lps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lp_i,
    input  logic [1:0] cfg_i,
    output logic       oe_o,
    output logic       ie_o
);
    logic oe_d, ie_d;

    // Purpose: decode the bank action into raw enable values.
    always_comb begin
        oe_d = 1'b1;
        ie_d = 1'b1;
        if (lp_i) begin
            case (bank_act_e'(cfg_i))
                BANK_OUT_OFF: oe_d = 1'b0;
                BANK_IN_OFF:  ie_d = 1'b0;
                BANK_ALL_OFF: begin
                    oe_d = 1'b0;
                    ie_d = 1'b0;
                end
                default: ;
            endcase
        end
    end

    // Purpose: register the enables so the pads see glitch-free levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_o <= 1'b1;
            ie_o <= 1'b1;
        end else begin
            oe_o <= oe_d;
            ie_o <= ie_d;
        end
    end

    // R4: outside low-power both enables are active one cycle later
    a_r4_normal_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        !lp_i |=> (oe_o && ie_o));

    // R3: code 00 never disables anything
    a_r3_keep_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i == 2'b00) |=> (oe_o && ie_o));
endmodule

// File: rtl/lps_sequencer.sv
// Module: low-power mode sequencer top. Gates per-bank pad enables while
// the request is high, optionally sleeps the PLL, and raises ready after a
// fixed resume delay once the PLL is locked.
// Assumes: CLK_FREQ_HZ is a whole number of MHz, at least 1 MHz.
module lps_sequencer #(
    parameter int unsigned NUM_BANKS   = 4,
    parameter int unsigned CLK_FREQ_HZ = 200_000_000,
    parameter int unsigned RESUME_US   = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lp_req_i,
    input  logic [2*NUM_BANKS-1:0] bank_cfg_i,
    input  logic                   pll_sleep_i,
    input  logic                   pll_lock_i,
    output logic [NUM_BANKS-1:0]   oe_o,
    output logic [NUM_BANKS-1:0]   ie_o,
    output logic                   pll_run_o,
    output logic                   ready_o
);
    localparam int unsigned CYC_PER_US    = CLK_FREQ_HZ / 1_000_000;
    localparam int unsigned RESUME_CYCLES =
        (CYC_PER_US * RESUME_US == 0) ? 1 : CYC_PER_US * RESUME_US;

    logic lp_s;
    logic timer_done;

    lps_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(lp_req_i),
        .sync_o (lp_s)
    );

    lps_resume_timer #(.CYCLES(RESUME_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .lp_i  (lp_s),
        .done_o(timer_done)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        lps_bank_gate u_gate (
            .clk  (clk),
            .rst_n(rst_n),
            .lp_i (lp_s),
            .cfg_i(bank_cfg_i[2*g +: 2]),
            .oe_o (oe_o[g]),
            .ie_o (ie_o[g])
        );
    end

    // Purpose: PLL run control and the resume-ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pll_run_o <= 1'b1;
            ready_o   <= 1'b0;
        end else begin
            pll_run_o <= !(lp_s && pll_sleep_i);
            ready_o   <= timer_done && !lp_s && pll_lock_i;
        end
    end

    // R5: no ready in the cycle after low-power is seen
    a_r5_no_ready_in_lp: assert property (@(posedge clk) disable iff (!rst_n)
        lp_s |=> !ready_o);

    // R7: ready implies the PLL is not being held in power-down
    a_r7_pll_on_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> pll_run_o);

    // R8: a lock loss clears ready on the next edge
    a_r8_lock_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_lock_i |=> !ready_o);
endmodule

// File: tb/sim_lps_sequencer.sv
module sim_lps_sequencer;
    localparam int NB = 4;
    localparam int N  = 10; // 1 MHz parameter x 10 us

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lp_req = 1'b0;
    logic [2*NB-1:0] cfg = '0;
    logic sleep = 1'b0;
    logic lock = 1'b1;
    logic [NB-1:0] oe, ie;
    logic pll_run, ready;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk; // 200 MHz

    lps_sequencer #(.NUM_BANKS(NB), .CLK_FREQ_HZ(1_000_000), .RESUME_US(10)) u0 (
        .clk(clk), .rst_n(rst_n), .lp_req_i(lp_req), .bank_cfg_i(cfg),
        .pll_sleep_i(sleep), .pll_lock_i(lock), .oe_o(oe), .ie_o(ie),
        .pll_run_o(pll_run), .ready_o(ready)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Measures the resume delay from a request fall made now.
    task automatic check_resume(input string req);
        lp_req = 1'b0;
        for (int k = 1; k <= N + 2; k++) begin
            step(1);
            chk(req, {31'd0, ready}, 32'd0);
        end
        step(1);
        chk(req, {31'd0, ready}, 32'd1);
    endtask

    initial begin
        // R1: reset state
        step(3);
        chk("R1 oe", {28'd0, oe}, 32'hF);
        chk("R1 ie", {28'd0, ie}, 32'hF);
        chk("R1 pll_run", {31'd0, pll_run}, 32'd1);
        chk("R1 ready", {31'd0, ready}, 32'd0);
        rst_n = 1'b1;
        step(N + 5);

        // R2: two-flop latency on entry
        cfg = 8'hFF;
        lp_req = 1'b1;
        step(2);
        chk("R2 not yet", {28'd0, oe}, 32'hF);
        step(1);
        chk("R2 applied", {28'd0, oe}, 32'h0);

        // R3 / R7: sweep every code set in low-power
        for (int i = 0; i < 256; i++) begin
            logic [NB-1:0] eo, ei;
            cfg = i[7:0];
            sleep = i[0] ^ i[3];
            step(2);
            for (int b = 0; b < NB; b++) begin
                eo[b] = !(i[2*b]);
                ei[b] = !(i[2*b+1]);
            end
            chk("R3 oe", {28'd0, oe}, {28'd0, eo});
            chk("R3 ie", {28'd0, ie}, {28'd0, ei});
            chk("R7 pll_run lp", {31'd0, pll_run}, {31'd0, !sleep});
            chk("R5 ready low in lp", {31'd0, ready}, 32'd0);
        end

        // R5: clean exit timing
        sleep = 1'b1;
        step(2);
        check_resume("R5 resume");

        // R4 / R7: codes ignored outside low-power
        for (int i = 0; i < 256; i++) begin
            cfg = i[7:0];
            sleep = i[1];
            step(2);
            chk("R4 oe", {28'd0, oe}, 32'hF);
            chk("R4 ie", {28'd0, ie}, 32'hF);
            chk("R7 pll_run normal", {31'd0, pll_run}, 32'd1);
        end

        // R6: reassertion mid-countdown restarts the delay
        lp_req = 1'b1;
        step(4);
        lp_req = 1'b0;
        step(6);
        chk("R6 mid ready", {31'd0, ready}, 32'd0);
        lp_req = 1'b1;
        step(3);
        check_resume("R6 restart");

        // R8: ready follows lock
        lock = 1'b0;
        step(1);
        chk("R8 lock drop", {31'd0, ready}, 32'd0);
        lock = 1'b1;
        step(1);
        chk("R8 lock back", {31'd0, ready}, 32'd1);

        // R8: exit with lock withheld
        lp_req = 1'b1;
        step(4);
        lock = 1'b0;
        lp_req = 1'b0;
        step(N + 6);
        chk("R8 no lock", {31'd0, ready}, 32'd0);
        lock = 1'b1;
        step(1);
        chk("R8 lock late", {31'd0, ready}, 32'd1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5 * 100_000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule